// File: doc/BRIEF.md
# Serial Digital Potentiometer Controller

This block is the control logic of a single-channel, 64-position digital potentiometer. A host reaches it over a three-wire serial link with an active-low select, a serial clock and a data line, plus a data-out line for reads. The block samples the link with its own system clock, decodes an instruction byte and carries out the command. It holds the wiper position register, a bank of four data registers that stand in for nonvolatile storage, and a busy flag that covers the fixed-length write time of that storage.

There are three kinds of command. Register transfers complete at the end of the instruction byte. Host reads and writes use one further data byte. The step command has no fixed length: after its instruction byte, every serial clock moves the wiper one position up or down, and the level of the data line picks the direction. The wiper code goes out on a registered output bus.

Top module: `sdpot_ctrl`

## Requirements
- R1: After reset the wiper output is 0, every data register holds 0, the busy flag is clear and `sdo` is 0.
- R2: While `cs_n` is low, bits are taken MSB first on each rising `sclk`. The first byte is the instruction: bits [7:4] are the opcode, bits [3:2] are reserved and must be 00, and bits [1:0] select one of the four data registers.
- R3: Opcode 0xA (write wiper) loads the low 6 bits of the second byte into the wiper on the 16th rising clock.
- R4: Opcodes 0x9 (read wiper), 0xB (read selected data register) and 0x5 (read status) drive the second byte on `sdo` MSB first as {2'b00, value}. Each bit is valid while `sclk` is low before the rising edge that consumes it. `sdo` is 0 while `cs_n` is high.
- R5: Opcode 0xC (write data register) stores the low 6 bits of the second byte into the selected data register and starts the busy period.
- R6: The read-status value carries the busy flag in bit 0. Busy stays set for exactly BUSY_CYCLES system clocks after a storage write is accepted.
- R7: While busy is set, opcodes 0xC and 0xE leave every data register unchanged. All other commands still take effect.
- R8: Opcode 0xD copies the selected data register into the wiper at the end of the instruction byte and does not set busy.
- R9: Opcode 0xE copies the wiper into the selected data register at the end of the instruction byte and starts the busy period.
- R10: After opcode 0x2, each further rising `sclk` moves the wiper up by one when `sdi` is 1 and down by one when it is 0. The wiper stops at 63 going up and at 0 going down, and the command runs until `cs_n` rises.
- R11: Raising `cs_n` abandons any unfinished command without effect, and the next falling `cs_n` begins a new instruction byte.
- R12: An opcode not listed above, or nonzero reserved bits, makes the whole command have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, slower than `clk` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, registered |
| wiper | output | WIDTH (6) | Wiper position code, registered |

## Verification
The hardest situation to reach from the ports is a storage write that arrives while an earlier one is still busy. The bench reaches it by starting a write and then issuing a second write straight away, with no idle time, so that it lands inside the busy window. A wiper write is sent in the same window to show that non-storage commands still act. Only after the busy period has run out does the bench read both registers back, which shows that the first write took effect and the second did not.

// File: rtl/sdpot_pkg.sv
package sdpot_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    OP_STEP          = 4'h2,
    OP_RD_STATUS     = 4'h5,
    OP_RD_WIPER      = 4'h9,
    OP_WR_WIPER      = 4'hA,
    OP_RD_DREG       = 4'hB,
    OP_WR_DREG       = 4'hC,
    OP_DREG_TO_WIPER = 4'hD,
    OP_WIPER_TO_DREG = 4'hE
  } op_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_DATA,
    PH_STEP,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/sdpot_sync.sv
module sdpot_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RST_VAL;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= RST_VAL;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sdpot_wiper.sv
module sdpot_wiper #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             step,
  input  logic             up,
  output logic [WIDTH-1:0] pos
);
  localparam logic [WIDTH-1:0] TOP_POS = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT_POS = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= BOT_POS;
    end else if (load) begin
      pos <= load_val;
    end else if (step) begin
      if (up && pos != TOP_POS)       pos <= pos + 1'b1;
      else if (!up && pos != BOT_POS) pos <= pos - 1'b1;
    end
  end
endmodule

// File: rtl/sdpot_nvbank.sv
module sdpot_nvbank #(
  parameter int WIDTH = 6,
  parameter int NREG = 4,
  parameter int BUSY_CYCLES = 400
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_req,
  input  logic [$clog2(NREG)-1:0] wr_sel,
  input  logic [WIDTH-1:0]        wr_val,
  output logic                    busy,
  output logic [NREG*WIDTH-1:0]   regs_flat
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [WIDTH-1:0] mem [NREG];
  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept = wr_req && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (accept) begin
      mem[wr_sel] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*WIDTH +: WIDTH] = mem[g];
  end
endmodule

// File: rtl/sdpot_ctrl.sv
module sdpot_ctrl
  import sdpot_pkg::*;
#(
  parameter int WIDTH = 6,
  parameter int NREG = 4,
  parameter int BUSY_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic [WIDTH-1:0] wiper
);
  localparam int SEL_W = $clog2(NREG);

  logic cs_s, sclk_s, sdi_s, sclk_q, rise, last_bit;
  logic [BYTE_W-1:0]   shifted, rd_word, out_q;
  logic [BYTE_W-2:0]   shreg;
  logic [2:0]          bit_cnt;
  logic [3:0]          cmd;
  logic [SEL_W-1:0]    sel, new_sel;
  phase_e              phase, cmd_phase;
  logic [NREG*WIDTH-1:0] regs_flat;
  logic                nv_busy;

  logic             wp_load, wp_step;
  logic [WIDTH-1:0] wp_val;
  logic             nv_req;
  logic [SEL_W-1:0] nv_sel;
  logic [WIDTH-1:0] nv_val;
  logic             rsv_ok;

  sdpot_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdi}), .q({cs_s, sclk_s, sdi_s})
  );

  assign rise     = sclk_s && !sclk_q && !cs_s;
  assign last_bit = (bit_cnt == 3'd7);
  assign shifted  = {shreg, sdi_s};
  assign new_sel  = shifted[SEL_W-1:0];
  assign rsv_ok   = (shifted[3:SEL_W] == '0);

  // Value returned by a read, picked when the instruction byte completes
  always_comb begin
    rd_word = '0;
    case (shifted[7:4])
      OP_RD_WIPER:  rd_word = BYTE_W'(wiper);
      OP_RD_DREG:   rd_word = BYTE_W'(regs_flat[new_sel*WIDTH +: WIDTH]);
      OP_RD_STATUS: rd_word = {{(BYTE_W-1){1'b0}}, nv_busy};
      default:      rd_word = '0;
    endcase
    if (!rsv_ok) rd_word = '0;
  end

  always_comb begin
    cmd_phase = PH_DONE;
    if (rsv_ok) begin
      case (shifted[7:4])
        OP_RD_WIPER, OP_RD_DREG, OP_RD_STATUS,
        OP_WR_WIPER, OP_WR_DREG:               cmd_phase = PH_DATA;
        OP_STEP:                               cmd_phase = PH_STEP;
        default:                               cmd_phase = PH_DONE;
      endcase
    end
  end

  // Action strobes toward wiper and storage bank
  always_comb begin
    wp_load = 1'b0;
    wp_val  = '0;
    wp_step = 1'b0;
    nv_req  = 1'b0;
    nv_sel  = sel;
    nv_val  = '0;
    if (rise) begin
      case (phase)
        PH_CMD: if (last_bit && rsv_ok) begin
          if (shifted[7:4] == OP_DREG_TO_WIPER) begin
            wp_load = 1'b1;
            wp_val  = regs_flat[new_sel*WIDTH +: WIDTH];
          end else if (shifted[7:4] == OP_WIPER_TO_DREG) begin
            nv_req = 1'b1;
            nv_sel = new_sel;
            nv_val = wiper;
          end
        end
        PH_DATA: if (last_bit) begin
          if (cmd == OP_WR_WIPER) begin
            wp_load = 1'b1;
            wp_val  = shifted[WIDTH-1:0];
          end else if (cmd == OP_WR_DREG) begin
            nv_req = 1'b1;
            nv_val = shifted[WIDTH-1:0];
          end
        end
        PH_STEP: wp_step = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      phase   <= PH_CMD;
      bit_cnt <= '0;
      shreg   <= '0;
      cmd     <= '0;
      sel     <= '0;
      out_q   <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (cs_s) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        out_q   <= '0;
      end else if (rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        shreg   <= shifted[BYTE_W-2:0];
        out_q   <= {out_q[BYTE_W-2:0], 1'b0};
        case (phase)
          PH_CMD: if (last_bit) begin
            cmd   <= shifted[7:4];
            sel   <= new_sel;
            out_q <= rd_word;
            phase <= cmd_phase;
          end
          PH_DATA: if (last_bit) phase <= PH_DONE;
          default: ;
        endcase
      end
    end
  end

  assign sdo = out_q[BYTE_W-1];

  sdpot_wiper #(.WIDTH(WIDTH)) u_wiper (
    .clk(clk), .rst(rst), .load(wp_load), .load_val(wp_val),
    .step(wp_step), .up(sdi_s), .pos(wiper)
  );

  sdpot_nvbank #(.WIDTH(WIDTH), .NREG(NREG), .BUSY_CYCLES(BUSY_CYCLES)) u_bank (
    .clk(clk), .rst(rst), .wr_req(nv_req), .wr_sel(nv_sel), .wr_val(nv_val),
    .busy(nv_busy), .regs_flat(regs_flat)
  );
endmodule

// File: rtl/sdpot_ctrl_chk.sv
module sdpot_ctrl_chk #(
  parameter int WIDTH = 6,
  parameter int NREG = 4,
  parameter int BUSY_CYCLES = 400
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cs_idle,
  input logic                  sdo,
  input logic [WIDTH-1:0]      wiper,
  input logic                  busy,
  input logic [NREG*WIDTH-1:0] regs_flat
);
  logic rst_q;
  int   run;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)       run <= 0;
    else if (busy) run <= run + 1;
    else           run <= 0;
  end

  always @(posedge clk) begin
    if (rst_q && !rst) begin
      // R1
      reset_state_chk: assert (wiper == '0 && regs_flat == '0 && !busy && !sdo);
    end
  end

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> $stable(wiper));

  // R4
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !sdo);

  // R7
  busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(regs_flat));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run < BUSY_CYCLES));
endmodule

bind sdpot_ctrl sdpot_ctrl_chk #(
  .WIDTH(WIDTH), .NREG(NREG), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cs_idle(cs_s), .sdo(sdo), .wiper(wiper),
  .busy(nv_busy), .regs_flat(regs_flat)
);

// File: tb/sim_sdpot_ctrl.sv
module sim_sdpot_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int BUSY = 400;

  localparam logic [3:0] OP_STEP = 4'h2, OP_RS = 4'h5, OP_RW = 4'h9, OP_WW = 4'hA,
                         OP_RD = 4'hB, OP_WD = 4'hC, OP_D2W = 4'hD, OP_W2D = 4'hE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  logic [5:0] wiper;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdpot_ctrl #(.WIDTH(6), .NREG(4), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo), .wiper(wiper)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b, output logic r);
    sdi = b;
    wait_clk(HALF);
    r = sdo;
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) put_bit(tx[i], rx[i]);
  endtask

  task automatic sel_on();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic sel_off();
    wait_clk(HALF);
    cs_n = 1'b1;
    sdi = 1'b0;
    wait_clk(8);
  endtask

  task automatic cmd2(input logic [3:0] op, input logic [1:0] rs,
                      input logic [7:0] tx, output logic [7:0] rx);
    logic [7:0] dummy;
    sel_on();
    put_byte({op, 2'b00, rs}, dummy);
    put_byte(tx, rx);
    sel_off();
  endtask

  task automatic cmd1(input logic [3:0] op, input logic [1:0] rs);
    logic [7:0] dummy;
    sel_on();
    put_byte({op, 2'b00, rs}, dummy);
    sel_off();
  endtask

  task automatic rd(input logic [3:0] op, input logic [1:0] rs, output int v);
    logic [7:0] rx;
    cmd2(op, rs, 8'h00, rx);
    v = int'(rx);
  endtask

  task automatic wr(input logic [3:0] op, input logic [1:0] rs, input logic [7:0] v);
    logic [7:0] rx;
    cmd2(op, rs, v, rx);
  endtask

  task automatic step_run(input logic [7:0] pattern, input int n);
    logic [7:0] dummy;
    logic r;
    sel_on();
    put_byte({OP_STEP, 4'b0000}, dummy);
    for (int i = 0; i < n; i++) put_bit(pattern[i], r);
    sel_off();
  endtask

  task automatic t_reset();
    int v;
    chk("R1 wiper after reset", int'(wiper), 0);
    chk("R1 sdo after reset", int'(sdo), 0);
    rd(OP_RS, 2'd0, v);
    chk("R6 status idle after reset", v, 0);
    rd(OP_RD, 2'd3, v);
    chk("R1 data register 3 after reset", v, 0);
  endtask

  task automatic t_wiper_rw();
    int v;
    wr(OP_WW, 2'd0, 8'h2A);   // R2 MSB-first pattern
    chk("R3 wiper write", int'(wiper), 42);
    rd(OP_RW, 2'd0, v);
    chk("R4 wiper read", v, 42);
    wr(OP_WW, 2'd0, 8'hFF);
    chk("R3 only low six bits", int'(wiper), 63);
    rd(OP_RW, 2'd0, v);
    chk("R4 upper read bits zero", v, 63);
  endtask

  task automatic t_dreg();
    int v;
    wr(OP_WD, 2'd2, 8'h15);
    rd(OP_RS, 2'd0, v);
    chk("R6 busy after storage write", v, 1);
    wait_clk(BUSY + 20);
    rd(OP_RS, 2'd0, v);
    chk("R6 busy cleared", v, 0);
    rd(OP_RD, 2'd2, v);
    chk("R5 data register 2", v, 21);
    rd(OP_RD, 2'd1, v);
    chk("R5 other register untouched", v, 0);
  endtask

  task automatic t_busy_lock();
    int v;
    wr(OP_WD, 2'd1, 8'h11);
    wr(OP_WD, 2'd0, 8'h3F);
    wr(OP_WW, 2'd0, 8'h05);
    chk("R7 wiper write during busy", int'(wiper), 5);
    wait_clk(BUSY + 20);
    rd(OP_RD, 2'd0, v);
    chk("R7 blocked write left register 0", v, 0);
    rd(OP_RD, 2'd1, v);
    chk("R7 first write kept", v, 17);
  endtask

  task automatic t_d2w();
    int v;
    logic [7:0] dummy;
    sel_on();
    put_byte({OP_D2W, 2'b00, 2'd2}, dummy);
    wait_clk(2);
    chk("R8 wiper loaded at byte end", int'(wiper), 21);
    sel_off();
    rd(OP_RS, 2'd0, v);
    chk("R8 no busy", v, 0);
  endtask

  task automatic t_w2d();
    int v;
    wr(OP_WW, 2'd0, 8'h33);
    cmd1(OP_W2D, 2'd3);
    rd(OP_RS, 2'd0, v);
    chk("R9 busy after transfer", v, 1);
    wait_clk(BUSY + 20);
    rd(OP_RD, 2'd3, v);
    chk("R9 register 3 holds wiper", v, 51);
  endtask

  task automatic t_step();
    wr(OP_WW, 2'd0, 8'd60);
    step_run(8'b0001_1111, 5);
    chk("R10 step up saturates at 63", int'(wiper), 63);
    wr(OP_WW, 2'd0, 8'd2);
    step_run(8'b0000_0000, 3);
    chk("R10 step down saturates at 0", int'(wiper), 0);
    wr(OP_WW, 2'd0, 8'd10);
    step_run(8'b0000_1011, 4);
    chk("R10 mixed steps", int'(wiper), 12);
  endtask

  task automatic t_abort();
    int v;
    logic [7:0] dummy;
    logic r;
    wr(OP_WW, 2'd0, 8'd20);
    sel_on();
    put_byte({OP_WW, 4'b0000}, dummy);
    for (int i = 0; i < 4; i++) put_bit(1'b1, r);
    sel_off();
    chk("R11 aborted write no effect", int'(wiper), 20);
    rd(OP_RW, 2'd0, v);
    chk("R11 fresh command after abort", v, 20);
  endtask

  task automatic t_unknown();
    int v;
    wr(4'h7, 2'd0, 8'h3F);
    chk("R12 undefined opcode", int'(wiper), 20);
    wr(OP_WW, 2'd0 | 2'd0, 8'h3F);
    sel_on();
    put_byte(8'hA4, dummy_b);
    put_byte(8'h01, dummy_b);
    sel_off();
    chk("R12 reserved bits set", int'(wiper), 63);
    rd(OP_RS, 2'd0, v);
    chk("R12 no busy from ignored command", v, 0);
  endtask

  logic [7:0] dummy_b;

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(1);
    t_reset();
    t_wiper_rw();
    t_dreg();
    t_busy_lock();
    t_d2w();
    t_w2d();
    wait_clk(BUSY + 20);
    t_step();
    t_abort();
    t_unknown();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule